// File: doc/BRIEF.md
# Paged Memory-Map Bus Router

This block sits between a CPU-side load/store port and a set of memory and peripheral targets. Each request carries a 32-bit address, an access size, a read/write flag and write data. The router picks one target from the top address byte only and aligns the address to the access size. It then raises exactly one target select strobe in the same cycle. The select is registered, so the read response, the selected target's data, comes back one cycle after the request.

Some regions get special treatment. A narrow backup region is 8 bits wide, so the router converts widths for it: it copies the returned byte across the access width on reads, and picks the addressed byte lane on writes. Writes are discarded silently in the cartridge pages. They are refused with an error in the boot ROM page. Byte writes to the three display memories are refused without an error. Pages that map to nothing read as zero and raise an error flag.

Top module: `pageRouter`

## Requirements
- R1: The page is reqAddr[31:24]. For a read, exactly one bit of tgtSel rises in the request cycle. The mapping is page 0x00 to bit 0 (boot ROM), 0x02 to bit 1 (external RAM), 0x03 to bit 2 (internal RAM), 0x04 to bit 3 (I/O), 0x05 to bit 4 (palette), 0x06 to bit 5 (video RAM), 0x07 to bit 6 (object attributes), 0x08 to 0x0D to bit 7 (cartridge) and 0x0E to 0x0F to bit 8 (backup).
- R2: Size is encoded as 0 for byte, 1 for halfword, 2 for word, and 3 is treated as word. In every region except backup, tgtAddr clears bits [1:0] for word accesses and bit [0] for halfword accesses, and is unchanged for byte accesses. The backup region always receives the unaligned address.
- R3: A backup read returns the low byte of the backup target's data. It is repeated once for a byte read, twice for a halfword read (upper half zero) and four times for a word read.
- R4: A backup write forwards on tgtWdata, zero-extended, the byte at lane (addr&3) for a word write, lane (addr&1) for a halfword write, and lane 0 for a byte write.
- R5: A write to pages 0x08 to 0x0D asserts no select and no error.
- R6: An access to any page other than 0x00 and 0x02 to 0x0F asserts no select. Its response has rspData zero and rspErr high.
- R7: A byte write to pages 0x05, 0x06 or 0x07 asserts no select and no error. A halfword write there is forwarded.
- R8: A write to page 0x00 asserts no select, and its response has rspErr high.
- R9: rspValid is high in the cycle after every request. A read's rspData is the selected target's tgtRdata slice (32 bits at index×32) sampled in that cycle.
- R10: tgtSize and tgtWrite carry the request's size and direction unchanged, so the I/O port can tell the access widths apart.
- R11: After reset, and in the cycle after a cycle with no request, rspValid and rspErr are low. With no request, tgtSel is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| reqAddr | input | 32 | Byte address |
| reqWdata | input | 32 | Write data |
| tgtSel | output | 9 | One-hot target select |
| tgtWrite | output | 1 | Forwarded direction |
| tgtSize | output | 2 | Forwarded size |
| tgtAddr | output | 32 | Aligned (or raw, for backup) address |
| tgtWdata | output | 32 | Write data, lane-selected for backup |
| tgtRdata | input | 288 | Read data of all targets, 32 bits each, target i at [i*32 +: 32] |
| rspValid | output | 1 | Response strobe, one cycle after request |
| rspData | output | 32 | Read data returned |
| rspErr | output | 1 | Undefined access or refused boot ROM write |

## Verification
The bench goes after page boundaries (0x01, 0x0D/0x0E, 0x0F/0x10, 0xFF). A decoder that used more or fewer address bits would select a target there, or miss one. It drives odd addresses at every size: a design that aligned the backup address, or used the wrong lane count, would forward a wrong address or byte. Backup data with all upper bits set shows a design that passed the full word through instead of repeating the byte. Byte writes to display memory and writes to the cartridge and boot pages show whether refusals leak a select strobe or get the error flag wrong.

// File: rtl/pageRouterPkg.sv
package pageRouterPkg;

  localparam int NUM_TGT = 9;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;

  typedef enum logic [3:0] {
    TGT_BOOT   = 4'd0,
    TGT_EWRAM  = 4'd1,
    TGT_IWRAM  = 4'd2,
    TGT_IO     = 4'd3,
    TGT_PAL    = 4'd4,
    TGT_VRAM   = 4'd5,
    TGT_OAM    = 4'd6,
    TGT_CART   = 4'd7,
    TGT_BACKUP = 4'd8,
    TGT_NONE   = 4'd9
  } tgtId_e;

  // Request-cycle strobes from control to datapath
  typedef struct packed {
    logic   fwd;
    logic   err;
    tgtId_e tgt;
  } fwdStrobe_t;

  // Registered response-cycle strobes from control to datapath
  typedef struct packed {
    logic       valid;
    logic       err;
    tgtId_e     tgt;
    logic [1:0] size;
  } rspStrobe_t;

endpackage

// File: rtl/pageRouterCtrl.sv
module pageRouterCtrl
  import pageRouterPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [ADDR_W-1:0] reqAddr,
  output fwdStrobe_t        fwdStb,
  output rspStrobe_t        rspStb
);

  localparam int PAGE_LO = ADDR_W - PAGE_W;

  logic [PAGE_W-1:0] page;
  logic              isByte;

  assign page   = reqAddr[ADDR_W-1:PAGE_LO];
  assign isByte = (reqSize == SZ_BYTE);

  always_comb begin
    fwdStb.fwd = 1'b0;
    fwdStb.err = 1'b0;
    fwdStb.tgt = TGT_NONE;
    if (page == PAGE_W'(0)) begin
      if (reqWrite) begin
        fwdStb.err = 1'b1;
      end else begin
        fwdStb.fwd = 1'b1;
        fwdStb.tgt = TGT_BOOT;
      end
    end else if (page == PAGE_W'(2) || page == PAGE_W'(3) || page == PAGE_W'(4)) begin
      fwdStb.fwd = 1'b1;
      fwdStb.tgt = (page == PAGE_W'(2)) ? TGT_EWRAM :
                   (page == PAGE_W'(3)) ? TGT_IWRAM : TGT_IO;
    end else if (page >= PAGE_W'(5) && page <= PAGE_W'(7)) begin
      if (!(reqWrite && isByte)) begin
        fwdStb.fwd = 1'b1;
        fwdStb.tgt = (page == PAGE_W'(5)) ? TGT_PAL :
                     (page == PAGE_W'(6)) ? TGT_VRAM : TGT_OAM;
      end
    end else if (page >= PAGE_W'(8) && page <= PAGE_W'(13)) begin
      if (!reqWrite) begin
        fwdStb.fwd = 1'b1;
        fwdStb.tgt = TGT_CART;
      end
    end else if (page == PAGE_W'(14) || page == PAGE_W'(15)) begin
      fwdStb.fwd = 1'b1;
      fwdStb.tgt = TGT_BACKUP;
    end else begin
      fwdStb.err = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspStb.valid <= 1'b0;
      rspStb.err   <= 1'b0;
      rspStb.tgt   <= TGT_NONE;
      rspStb.size  <= SZ_BYTE;
    end else begin
      rspStb.valid <= reqValid;
      rspStb.err   <= reqValid && fwdStb.err;
      rspStb.tgt   <= (reqValid && fwdStb.fwd) ? fwdStb.tgt : TGT_NONE;
      rspStb.size  <= reqSize;
    end
  end

endmodule

// File: rtl/pageRouterData.sv
module pageRouterData
  import pageRouterPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic                      reqValid,
  input  logic [1:0]                reqSize,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  input  fwdStrobe_t                fwdStb,
  input  rspStrobe_t                rspStb,
  input  logic [NUM_TGT*DATA_W-1:0] tgtRdata,
  output logic [NUM_TGT-1:0]        tgtSel,
  output logic [ADDR_W-1:0]         tgtAddr,
  output logic [DATA_W-1:0]         tgtWdata,
  output logic [DATA_W-1:0]         rspData
);

  localparam int LANES = DATA_W / 8;

  // One select line per target
  for (genvar i = 0; i < NUM_TGT; i++) begin : g_sel
    assign tgtSel[i] = reqValid && fwdStb.fwd && (fwdStb.tgt == tgtId_e'(i));
  end

  logic isBackup;
  assign isBackup = (fwdStb.tgt == TGT_BACKUP);

  // Address alignment
  always_comb begin
    tgtAddr = reqAddr;
    if (!isBackup) begin
      if (reqSize[1])      tgtAddr[1:0] = 2'b00;
      else if (reqSize[0]) tgtAddr[0]   = 1'b0;
    end
  end

  // Backup write lane pick (rotate right, keep low byte)
  logic [1:0]        laneIdx;
  logic [DATA_W-1:0] shifted;
  always_comb begin
    if (reqSize[1])      laneIdx = reqAddr[1:0];
    else if (reqSize[0]) laneIdx = {1'b0, reqAddr[0]};
    else                 laneIdx = 2'b00;
    shifted  = reqWdata >> {laneIdx, 3'b000};
    tgtWdata = isBackup ? {{(DATA_W-8){1'b0}}, shifted[7:0]} : reqWdata;
  end

  // Response mux from registered select
  logic [DATA_W-1:0] rdSel;
  always_comb begin
    rdSel = '0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (rspStb.tgt == tgtId_e'(i)) rdSel = tgtRdata[i*DATA_W +: DATA_W];
    end
  end

  // Byte replication for backup reads
  int                laneCnt;
  logic [DATA_W-1:0] replWord;
  assign laneCnt = rspStb.size[1] ? LANES : (rspStb.size[0] ? 2 : 1);

  for (genvar k = 0; k < LANES; k++) begin : g_repl
    assign replWord[k*8 +: 8] = (k < laneCnt) ? rdSel[7:0] : 8'h00;
  end

  always_comb begin
    if (!rspStb.valid)                rspData = '0;
    else if (rspStb.tgt == TGT_BACKUP) rspData = replWord;
    else                               rspData = rdSel;
  end

endmodule

// File: rtl/pageRouter.sv
module pageRouter
  import pageRouterPkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int PAGE_W = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      reqValid,
  input  logic                      reqWrite,
  input  logic [1:0]                reqSize,
  input  logic [ADDR_W-1:0]         reqAddr,
  input  logic [DATA_W-1:0]         reqWdata,
  output logic [NUM_TGT-1:0]        tgtSel,
  output logic                      tgtWrite,
  output logic [1:0]                tgtSize,
  output logic [ADDR_W-1:0]         tgtAddr,
  output logic [DATA_W-1:0]         tgtWdata,
  input  logic [NUM_TGT*DATA_W-1:0] tgtRdata,
  output logic                      rspValid,
  output logic [DATA_W-1:0]         rspData,
  output logic                      rspErr
);

  fwdStrobe_t fwdStb;
  rspStrobe_t rspStb;

  pageRouterCtrl #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqAddr(reqAddr), .fwdStb(fwdStb), .rspStb(rspStb)
  );

  pageRouterData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .reqValid(reqValid), .reqSize(reqSize), .reqAddr(reqAddr),
    .reqWdata(reqWdata), .fwdStb(fwdStb), .rspStb(rspStb),
    .tgtRdata(tgtRdata), .tgtSel(tgtSel), .tgtAddr(tgtAddr),
    .tgtWdata(tgtWdata), .rspData(rspData)
  );

  assign tgtWrite = reqWrite;
  assign tgtSize  = reqSize;
  assign rspValid = rspStb.valid;
  assign rspErr   = rspStb.err;

endmodule

// File: rtl/pageRouterChecker.sv
module pageRouterChecker (
  input logic         clk,
  input logic         rstN,
  input logic         reqValid,
  input logic         reqWrite,
  input logic [1:0]   reqSize,
  input logic [31:0]  reqAddr,
  input logic [31:0]  reqWdata,
  input logic [8:0]   tgtSel,
  input logic         tgtWrite,
  input logic [1:0]   tgtSize,
  input logic [31:0]  tgtAddr,
  input logic [31:0]  tgtWdata,
  input logic [287:0] tgtRdata,
  input logic         rspValid,
  input logic [31:0]  rspData,
  input logic         rspErr
);

  logic [7:0] pg;
  assign pg = reqAddr[31:24];

  assert_sel_onehot_R1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tgtSel));

  assert_word_align_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|tgtSel[7:0] && tgtSize[1]) |-> (tgtAddr[1:0] == 2'b00));

  assert_cart_wr_drop_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && pg >= 8'h08 && pg <= 8'h0D) |-> (tgtSel == 9'd0));

  assert_cart_wr_noerr_R5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && pg >= 8'h08 && pg <= 8'h0D) |=> !rspErr);

  assert_unmapped_err_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && pg > 8'h0F) |=> (rspErr && rspData == 32'd0));

  assert_unmapped_nosel_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && (pg > 8'h0F || pg == 8'h01)) |-> (tgtSel == 9'd0));

  assert_boot_wr_err_R8: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite && pg == 8'h00) |=> rspErr);

  assert_rsp_follows_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> (!rspValid && !rspErr));

  assert_idle_nosel_R11: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |-> (tgtSel == 9'd0));

endmodule

bind pageRouter pageRouterChecker uChk (.*);

// File: tb/sim_pageRouter.sv
module sim_pageRouter;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         reqValid = 1'b0;
  logic         reqWrite = 1'b0;
  logic [1:0]   reqSize = 2'd0;
  logic [31:0]  reqAddr = '0;
  logic [31:0]  reqWdata = '0;
  logic [8:0]   tgtSel;
  logic         tgtWrite;
  logic [1:0]   tgtSize;
  logic [31:0]  tgtAddr;
  logic [31:0]  tgtWdata;
  logic [287:0] tgtRdata;
  logic         rspValid;
  logic [31:0]  rspData;
  logic         rspErr;

  int nChecks = 0;
  int nFails  = 0;
  logic [7:0] bkByte = 8'h5A;

  always #4 clk = ~clk;

  function automatic logic [31:0] stubVal(input int i);
    return 32'hA000_1234 | (32'(i) << 20);
  endfunction

  always_comb begin
    for (int i = 0; i < 8; i++) tgtRdata[i*32 +: 32] = stubVal(i);
    tgtRdata[8*32 +: 32] = {24'hFFFFFF, bkByte};
  end

  pageRouter u0 (.*);

  // captured values
  logic [8:0]  cSel;
  logic [31:0] cAddr, cWdata, cRsp;
  logic [1:0]  cSize;
  logic        cWrite, cVal, cErr;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [1:0] sz, input logic [31:0] a, input logic [31:0] wd);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = a; reqWdata = wd;
    #1;
    cSel = tgtSel; cAddr = tgtAddr; cWdata = tgtWdata; cSize = tgtSize; cWrite = tgtWrite;
    @(negedge clk);
    cVal = rspValid; cRsp = rspData; cErr = rspErr;
    reqValid = 1'b0;
  endtask

  function automatic int expIdx(input int p);
    if (p == 0) return 0;
    if (p >= 2 && p <= 7) return p - 1;
    if (p >= 8 && p <= 13) return 7;
    if (p == 14 || p == 15) return 8;
    return 9;
  endfunction

  task automatic testReset();
    chk(!rspValid && !rspErr, "R11 reset", {30'd0, rspValid, rspErr}, 32'd0);
    chk(tgtSel == 9'd0, "R11 reset sel", 32'(tgtSel), 32'd0);
  endtask

  task automatic testDecode();
    int pages[20] = '{0,1,2,3,4,5,6,7,8,9,10,11,12,13,14,15,16,32,127,255};
    foreach (pages[n]) begin
      int p = pages[n];
      int e = expIdx(p);
      access(1'b0, 2'd2, {8'(p), 24'h000100}, 32'd0);
      if (e < 9) begin
        chk(cSel == 9'(1 << e), "R1 select", 32'(cSel), 32'(1 << e));
        chk(cVal && cErr == 1'b0, "R9 rsp valid", {30'd0, cVal, cErr}, 32'd2);
        if (e != 8) chk(cRsp == stubVal(e), "R9 read data", cRsp, stubVal(e));
      end else begin
        chk(cSel == 9'd0, "R6 no select", 32'(cSel), 32'd0);
        chk(cVal && cErr && cRsp == 0, "R6 err zero", cRsp, 32'd0);
      end
    end
  endtask

  task automatic testAlign();
    access(1'b0, 2'd2, 32'h0200_0007, 0);
    chk(cAddr == 32'h0200_0004, "R2 word align", cAddr, 32'h0200_0004);
    access(1'b0, 2'd3, 32'h0300_0003, 0);
    chk(cAddr == 32'h0300_0000, "R2 size3 align", cAddr, 32'h0300_0000);
    access(1'b0, 2'd1, 32'h0600_0013, 0);
    chk(cAddr == 32'h0600_0012, "R2 half align", cAddr, 32'h0600_0012);
    access(1'b0, 2'd0, 32'h0800_0013, 0);
    chk(cAddr == 32'h0800_0013, "R2 byte keep", cAddr, 32'h0800_0013);
    access(1'b0, 2'd2, 32'h0E00_0003, 0);
    chk(cAddr == 32'h0E00_0003, "R2 backup raw", cAddr, 32'h0E00_0003);
  endtask

  task automatic testBackupRead();
    bkByte = 8'h5A;
    access(1'b0, 2'd2, 32'h0E00_0001, 0);
    chk(cRsp == 32'h5A5A5A5A, "R3 word repl", cRsp, 32'h5A5A5A5A);
    bkByte = 8'hC3;
    access(1'b0, 2'd1, 32'h0F00_0001, 0);
    chk(cRsp == 32'h0000C3C3, "R3 half repl", cRsp, 32'h0000C3C3);
    access(1'b0, 2'd0, 32'h0E00_0002, 0);
    chk(cRsp == 32'h000000C3, "R3 byte", cRsp, 32'h000000C3);
  endtask

  task automatic testBackupWrite();
    for (int o = 0; o < 4; o++) begin
      logic [31:0] e = 32'((32'h44332211 >> (8*o)) & 32'hFF);
      access(1'b1, 2'd2, 32'h0E00_0010 + 32'(o), 32'h44332211);
      chk(cSel == 9'h100 && cWdata == e, "R4 word lane", cWdata, e);
    end
    access(1'b1, 2'd1, 32'h0E00_0003, 32'h44332211);
    chk(cWdata == 32'h22, "R4 half lane", cWdata, 32'h22);
    access(1'b1, 2'd0, 32'h0F00_0003, 32'h44332211);
    chk(cWdata == 32'h11, "R4 byte lane", cWdata, 32'h11);
  endtask

  task automatic testCartWrite();
    access(1'b1, 2'd2, 32'h0800_0000, 32'h1);
    chk(cSel == 0 && !cErr, "R5 cart low", 32'(cSel), 32'd0);
    access(1'b1, 2'd1, 32'h0D00_0000, 32'h1);
    chk(cSel == 0 && !cErr, "R5 cart high", 32'(cSel), 32'd0);
  endtask

  task automatic testUnmappedWrite();
    access(1'b1, 2'd0, 32'h1000_0000, 32'h1);
    chk(cSel == 0 && cErr && cVal, "R6 unmapped write", {30'd0, cVal, cErr}, 32'd3);
  endtask

  task automatic testDisplayByte();
    for (int p = 5; p <= 7; p++) begin
      access(1'b1, 2'd0, {8'(p), 24'h10}, 32'hFF);
      chk(cSel == 0 && !cErr, "R7 byte refused", 32'(cSel), 32'd0);
    end
    access(1'b1, 2'd1, 32'h0500_0002, 32'hBEEF);
    chk(cSel == 9'h010 && cWdata == 32'hBEEF, "R7 half allowed", 32'(cSel), 32'h10);
  endtask

  task automatic testBootWrite();
    access(1'b1, 2'd2, 32'h0000_0040, 32'h1);
    chk(cSel == 0 && cErr, "R8 boot write", {23'd0, cSel}, 32'd0);
  endtask

  task automatic testIoSize();
    for (int s = 0; s < 3; s++) begin
      access(1'b1, 2'(s), 32'h0400_0006, 32'h12);
      chk(cSel == 9'h008 && cSize == 2'(s) && cWrite, "R10 io size", 32'(cSize), 32'(s));
    end
  endtask

  task automatic testIdle();
    @(negedge clk); reqValid = 1'b0; reqAddr = 32'h1000_0000;
    #1 chk(tgtSel == 0, "R11 idle sel", 32'(tgtSel), 32'd0);
    @(negedge clk);
    chk(!rspValid && !rspErr, "R11 idle rsp", {30'd0, rspValid, rspErr}, 32'd0);
  endtask

  initial begin
    #(8 * 200000);
    nFails++; nChecks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #1 testReset();
    #20 rstN = 1'b1;
    testReset();
    testDecode();
    testAlign();
    testBackupRead();
    testBackupWrite();
    testCartWrite();
    testUnmappedWrite();
    testDisplayByte();
    testBootWrite();
    testIoSize();
    testIdle();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule